// File: doc/BRIEF.md
# Presettable Up/Down Cascadable Counter

This block is one stage of a synchronous binary counter that steps up or down by one on each rising clock edge. It can be preset to any value from a parallel data bus. It has two active-low count enables and an active-low terminal-count output. Wider counters are built by chaining stages: every stage shares the clock, direction, preset strobe and parallel enable, and the terminal count of each stage drives the trickle enable of the next, more significant stage. No extra gating is needed between stages.

The stage has no reset. Its state is unknown until the first preset, so a user presets it before relying on the count. The stage width is a parameter, with a default of 4 bits, which gives a modulo-16 count.

Top module: `updn_cnt_stage`

## Requirements
- R1: When `load_n` is 0 at a rising edge, `q` takes the value of `din` on that edge, whatever the levels of `up`, `cep_n` and `cet_n`. Load has the highest priority.
- R2: When `load_n` is 1, `cep_n` is 0, `cet_n` is 0 and `up` is 1, `q` increases by one on the edge. It wraps from all-ones (15) to 0.
- R3: When `load_n` is 1, `cep_n` is 0, `cet_n` is 0 and `up` is 0, `q` decreases by one on the edge. It wraps from 0 to all-ones (15).
- R4: When `load_n` is 1 and either `cep_n` or `cet_n` is 1, `q` keeps its value across the edge.
- R5: `tc_n` is 0 exactly when `cet_n` is 0 and either `up` is 1 with `q` at all-ones, or `up` is 0 with `q` at 0. Otherwise `tc_n` is 1. `tc_n` does not depend on `cep_n`. The same decode applies while `load_n` is 0.
- R6: `tc_n` is combinational. It follows a change on `up` or `cet_n` within the same clock period, without waiting for an edge.
- R7: When three stages share `clk`, `up`, `load_n` and `cep_n`, and each stage's `tc_n` drives the next stage's `cet_n`, the chain behaves as one 12-bit counter with the same load, count, hold and terminal-count rules as a single stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes happen on the rising edge |
| din | input | WIDTH | Parallel preset data |
| load_n | input | 1 | Active-low synchronous preset |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| cep_n | input | 1 | Active-low parallel count enable |
| cet_n | input | 1 | Active-low trickle count enable; also gates `tc_n` |
| q | output | WIDTH | Present count |
| tc_n | output | 1 | Active-low terminal count |

## Verification
The bench drives a three-stage chain and targets the 4095-to-0 and 0-to-4095 wraps across all stages. A stage that dropped its carry or borrow would show the upper nibbles stalling or jumping at those points. The bench holds `tc_n` at its terminal state with `cep_n` high and with `load_n` low. A decode that wrongly included either signal would release `tc_n` there. It also toggles `up` and `cet_n` between edges, which exposes a registered terminal count. Finally, it presets the chain while the enables are high; a design that let the enables block the load would keep the old count.

// File: rtl/updn_cnt_stage.sv
module updn_cnt_stage #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  input  logic             load_n,
  input  logic             up,
  input  logic             cep_n,
  input  logic             cet_n,
  output logic [WIDTH-1:0] q,
  output logic             tc_n
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic             step_en;
  logic [WIDTH-1:0] q_next;
  logic             at_end;

  assign step_en = ~cep_n & ~cet_n;
  assign q_next  = up ? q + ONE : q - ONE;
  assign at_end  = up ? (q == TOP) : (q == '0);
  assign tc_n    = ~(at_end & ~cet_n);

  always_ff @(posedge clk) begin
    if (!load_n)      q <= din;
    else if (step_en) q <= q_next;
  end
endmodule

// File: rtl/updn_cnt_stage_chk.sv
module updn_cnt_stage_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic [WIDTH-1:0] din,
  input logic             load_n,
  input logic             up,
  input logic             cep_n,
  input logic             cet_n,
  input logic [WIDTH-1:0] q,
  input logic             tc_n
);
  logic primed = 1'b0;
  always_ff @(posedge clk) if (!load_n) primed <= 1'b1;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!primed)
    !load_n |=> q == $past(din)); // R1
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!primed)
    (load_n && !cep_n && !cet_n && up) |=> q == WIDTH'($past(q) + 1'b1)); // R2
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!primed)
    (load_n && !cep_n && !cet_n && !up) |=> q == WIDTH'($past(q) - 1'b1)); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!primed)
    (load_n && (cep_n || cet_n)) |=> $stable(q)); // R4
  AST_TC_GATED: assert property (@(posedge clk) disable iff (!primed)
    cet_n |-> tc_n); // R5
  AST_TC_NEEDS_END: assert property (@(posedge clk) disable iff (!primed)
    !tc_n |-> (up ? &q : ~|q)); // R5
endmodule

bind updn_cnt_stage updn_cnt_stage_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .din(din), .load_n(load_n), .up(up), .cep_n(cep_n),
  .cet_n(cet_n), .q(q), .tc_n(tc_n)
);

// File: tb/updn_cnt_stage_tb.sv
module updn_cnt_stage_tb;
  logic        clk = 1'b0;
  logic [11:0] din = '0;
  logic        load_n = 1'b1, up = 1'b1, cep_n = 1'b1, cet_n = 1'b1;
  logic [11:0] q;
  logic        tc0, tc1, tc2;
  int          n_chk = 0, n_bad = 0;
  logic [11:0] model = '0;

  always #2 clk = ~clk;

  updn_cnt_stage #(.WIDTH(4)) u_dut (.clk(clk), .din(din[3:0]), .load_n(load_n), .up(up),
    .cep_n(cep_n), .cet_n(cet_n), .q(q[3:0]), .tc_n(tc0));
  updn_cnt_stage #(.WIDTH(4)) u_mid (.clk(clk), .din(din[7:4]), .load_n(load_n), .up(up),
    .cep_n(cep_n), .cet_n(tc0), .q(q[7:4]), .tc_n(tc1));
  updn_cnt_stage #(.WIDTH(4)) u_top (.clk(clk), .din(din[11:8]), .load_n(load_n), .up(up),
    .cep_n(cep_n), .cet_n(tc1), .q(q[11:8]), .tc_n(tc2));

  function automatic logic exp_tc(input logic [11:0] v, input int bits);
    logic [11:0] m = (12'hFFF >> (12 - bits));
    return !(!cet_n && (up ? ((v & m) == m) : ((v & m) == 0)));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_tc(input string req);
    check(req, tc0, exp_tc(model, 4));
    check(req, tc2, exp_tc(model, 12));
  endtask

  task automatic tick(input string req);
    @(posedge clk);
    if (!load_n) model = din;
    else if (!cep_n && !cet_n) model = up ? model + 12'd1 : model - 12'd1;
    @(negedge clk);
    check(req, q, model);
    check_tc(req);
  endtask

  task automatic preset(input logic [11:0] v);
    load_n = 1'b0; din = v;
    tick("R1");
    load_n = 1'b1;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    // R1: preset with both enables high, then with both low
    preset(12'h7F7);
    cep_n = 0; cet_n = 0; up = 0;
    preset(12'hFFD);
    // R2, R7: count up across the full 12-bit wrap
    up = 1;
    for (int i = 0; i < 5; i++) tick("R2 R7");
    check("R2", q, 12'h002);
    // R4: inhibit with each enable in turn
    cep_n = 1; tick("R4"); tick("R4");
    cep_n = 0; cet_n = 1; tick("R4");
    check("R4", q, 12'h002);
    // R3, R7: count down through zero
    cet_n = 0; up = 0;
    for (int i = 0; i < 5; i++) tick("R3 R7");
    check("R3", q, 12'hFFD);
    // R5: terminal count ignores cep_n and stays live during load
    preset(12'hFFF); up = 1; cep_n = 1; #1;
    check("R5", tc2, 0);
    load_n = 0; din = 12'h123; #1;
    check("R5", tc0, 0);
    tick("R1");
    load_n = 1;
    // R6: combinational response to up and cet_n between edges
    preset(12'h000); up = 1; cet_n = 0; #1;
    check("R6", tc0, 1);
    up = 0; #1;
    check("R6", tc0, 0);
    check("R6", tc2, 0);
    cet_n = 1; #1;
    check("R6", tc0, 1);
    // random mix
    for (int i = 0; i < 400; i++) begin
      load_n = ($urandom % 16) != 0;
      din    = 12'($urandom);
      up     = 1'($urandom);
      cep_n  = ($urandom % 5) == 0;
      cet_n  = ($urandom % 5) == 0;
      if ((i % 50) == 7) begin load_n = 0; din = up ? 12'hFFE : 12'h001; end
      tick("R7");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule